// File: doc/BRIEF.md
# External Bus Access Stretch Controller

This block lengthens each access to the external address space by a programmable number of extra clock cycles. While an access is being lengthened, the bus master sees a stall signal. When the access ends, the block gives a single-cycle done pulse. An optional external wait input can hold the access open past the programmed count, but the programmed count always runs in full first.

An 8-bit control register sets the behaviour. It holds a wait-enable flag and a 3-bit stretch field. The register can be read and written at any time. Lengthening applies only in the two expanded operating modes, and only to accesses that decode to external space. Every other access completes in the next cycle without a stall. The count for an access is captured when the access is accepted, so later register writes apply only from the next access onward.

Top module: `xbus_stretch`

## Requirements
- R1: After reset, the register reads 0x07 (wait disabled, stretch field 111), and `stall` and `acc_done` are both low.
- R2: Bit 7 of the register is the wait enable and bits 2:0 are the stretch field. Bits 6:3 always read as zero. A write takes effect on the next edge, in any mode and at any time, and `reg_rdata` shows the stored value continuously.
- R3: Wait is disabled, the mode is expanded and the access is external, with field value N. `stall` is high for exactly N+1 cycles, starting in the cycle after the accepting edge. The wait pin has no effect.
- R4: Wait is enabled. The minimum stall length is 2 for N=0 and N+1 for every other N.
- R5: Wait is enabled and the minimum has run out. `ext_wait` is sampled on each edge. The stall continues while it is high and ends at the first edge where it is low.
- R6: Mode codes 2 (normal expanded) and 3 (emulation expanded) allow stretching. In every other mode code, an access completes with `acc_done` in the next cycle, no stall, and `ext_wait` is ignored.
- R7: An access with `acc_ext` low completes with `acc_done` in the next cycle and no stall.
- R8: The stall length of an access comes from the register value before the accepting edge. Writes during the access, or at that same edge, apply only from the next access.
- R9: `acc_done` is high for exactly one cycle, in the cycle right after the last stall cycle. `stall` is low whenever `acc_done` is high.
- R10: An `acc_start` pulse that arrives while `stall` is high is ignored and does not change the length of the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| acc_start | input | 1 | Access start strobe, accepted when not stalled |
| acc_ext | input | 1 | Access decodes to external space |
| mode | input | 3 | Operating mode code |
| ext_wait | input | 1 | External wait input, active high |
| stall | output | 1 | Bus stall, high during every stretch cycle |
| acc_done | output | 1 | One-cycle end-of-access pulse |

## Verification
An access accepted at edge E shows `stall` starting in the cycle after E. An unstretched access instead shows `acc_done` in that cycle. A stretched access of S stall cycles shows `acc_done` S+1 cycles after E. A register write shows on `reg_rdata` in the cycle after its edge.

The bench drives inputs on falling edges. Its reference model advances on each rising edge, and the outputs are compared with the model on each falling edge, so every comparison lands in the cycle where the result is due. Directed tasks also count stall cycles and compare the total with the expected minimum or hold length.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int XBS_REG_W   = 8;
  localparam int XBS_FLD_W   = 3;
  localparam int XBS_WEN_BIT = 7;
  localparam int XBS_MODE_W  = 3;
  localparam int XBS_CNT_W   = XBS_FLD_W + 1;
  localparam int XBS_RUN_W   = 8;

  localparam logic [XBS_MODE_W-1:0] MODE_NORM_EXP = 3'd2;
  localparam logic [XBS_MODE_W-1:0] MODE_EMUL_EXP = 3'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MIN  = 2'd1,
    ST_HOLD = 2'd2
  } xbs_state_e;

  // Minimum stall cycles for a field value, with a floor of 2 when wait is enabled.
  function automatic logic [XBS_CNT_W-1:0] min_stretch(
      input logic [XBS_FLD_W-1:0] fld, input logic wen);
    logic [XBS_CNT_W-1:0] n;
    n = {1'b0, fld} + 1'b1;
    if (wen && n < 2) n = 2;
    return n;
  endfunction

  function automatic logic mode_expanded(input logic [XBS_MODE_W-1:0] md);
    return (md == MODE_NORM_EXP) || (md == MODE_EMUL_EXP);
  endfunction

  function automatic logic bit_implemented(input int b);
    return (b == XBS_WEN_BIT) || (b < XBS_FLD_W);
  endfunction
endpackage

// File: rtl/xbs_ctrl_reg.sv
module xbs_ctrl_reg
  import xbs_pkg::*;
#(
  parameter int REG_W   = XBS_REG_W,
  parameter int FLD_W   = XBS_FLD_W,
  parameter int WEN_BIT = XBS_WEN_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             wait_en,
  output logic [FLD_W-1:0] fld
);
  localparam logic [REG_W-1:0] RST_VAL = REG_W'((1 << FLD_W) - 1);

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if ((b == WEN_BIT) || (b < FLD_W)) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL[b];
        else if (we) q <= wdata[b];
      end
      assign rdata[b] = q;
    end else begin : g_rsv
      assign rdata[b] = 1'b0;
    end
  end

  assign wait_en = rdata[WEN_BIT];
  assign fld     = rdata[FLD_W-1:0];
endmodule

// File: rtl/xbs_gate.sv
module xbs_gate
  import xbs_pkg::*;
#(
  parameter int MODE_W = XBS_MODE_W
) (
  input  logic              acc_start,
  input  logic              acc_ext,
  input  logic [MODE_W-1:0] mode,
  input  logic              busy,
  output logic              stretch_fire,
  output logic              plain_fire
);
  logic accept;
  logic stretch_ok;

  assign accept       = acc_start && !busy;
  assign stretch_ok   = acc_ext && mode_expanded(mode);
  assign stretch_fire = accept && stretch_ok;
  assign plain_fire   = accept && !stretch_ok;
endmodule

// File: rtl/xbs_stretch_fsm.sv
module xbs_stretch_fsm
  import xbs_pkg::*;
#(
  parameter int CNT_W = XBS_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stretch_fire,
  input  logic             plain_fire,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             load_wen,
  input  logic             ext_wait,
  output logic             stall,
  output logic             done,
  output logic             min_expired,
  output logic             finish
);
  xbs_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             wen_q;
  logic             wait_hold;

  assign min_expired = (state == ST_MIN) && (cnt == '0);
  assign wait_hold   = wen_q && ext_wait;
  assign finish      = (min_expired && !wait_hold) ||
                       ((state == ST_HOLD) && !ext_wait);
  assign stall       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      wen_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= finish || plain_fire;
      unique case (state)
        ST_IDLE: begin
          if (stretch_fire) begin
            state <= ST_MIN;
            cnt   <= load_cnt - 1'b1;
            wen_q <= load_wen;
          end
        end
        ST_MIN: begin
          if (cnt != '0)     cnt   <= cnt - 1'b1;
          else if (wait_hold) state <= ST_HOLD;
          else               state <= ST_IDLE;
        end
        ST_HOLD: begin
          if (!ext_wait) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_stretch.sv
module xbus_stretch
  import xbs_pkg::*;
#(
  parameter int REG_W   = XBS_REG_W,
  parameter int FLD_W   = XBS_FLD_W,
  parameter int WEN_BIT = XBS_WEN_BIT,
  parameter int MODE_W  = XBS_MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              acc_start,
  input  logic              acc_ext,
  input  logic [MODE_W-1:0] mode,
  input  logic              ext_wait,
  output logic              stall,
  output logic              acc_done
);
  localparam int CNT_W = FLD_W + 1;

  logic             wait_en;
  logic [FLD_W-1:0] fld;
  logic             stretch_fire;
  logic             plain_fire;
  logic             min_expired;
  logic             finish;
  logic [CNT_W-1:0] load_cnt;

  assign load_cnt = min_stretch(fld, wait_en);

  xbs_ctrl_reg #(.REG_W(REG_W), .FLD_W(FLD_W), .WEN_BIT(WEN_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .wait_en(wait_en), .fld(fld)
  );

  xbs_gate #(.MODE_W(MODE_W)) u_gate (
    .acc_start(acc_start), .acc_ext(acc_ext), .mode(mode), .busy(stall),
    .stretch_fire(stretch_fire), .plain_fire(plain_fire)
  );

  xbs_stretch_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .stretch_fire(stretch_fire),
    .plain_fire(plain_fire), .load_cnt(load_cnt), .load_wen(wait_en),
    .ext_wait(ext_wait), .stall(stall), .done(acc_done),
    .min_expired(min_expired), .finish(finish)
  );
endmodule

// File: rtl/xbus_stretch_chk.sv
module xbus_stretch_chk
  import xbs_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [XBS_REG_W-1:0]  reg_rdata,
  input logic                  acc_start,
  input logic                  acc_ext,
  input logic [XBS_MODE_W-1:0] mode,
  input logic                  stall,
  input logic                  acc_done
);
  logic [XBS_RUN_W-1:0] run;
  logic [XBS_CNT_W-1:0] lat_min;
  logic                 lat_wen;
  logic                 exp_mode;

  assign exp_mode = mode_expanded(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= '0;
      lat_min <= '0;
      lat_wen <= 1'b0;
    end else begin
      if (stall) run <= (run == '1) ? run : run + 1'b1;
      else       run <= '0;
      if (acc_start && !stall) begin
        lat_min <= min_stretch(reg_rdata[XBS_FLD_W-1:0], reg_rdata[XBS_WEN_BIT]);
        lat_wen <= reg_rdata[XBS_WEN_BIT];
      end
    end
  end

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[XBS_WEN_BIT-1:XBS_FLD_W] == '0);
  assert_exact_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stall) && !lat_wen) |-> (run == XBS_RUN_W'(lat_min)));
  assert_min_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (run >= XBS_RUN_W'(lat_min)));
  assert_mode_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !stall && !exp_mode) |=> (acc_done && !stall));
  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(acc_start && acc_ext && exp_mode));
  assert_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !stall && !acc_ext) |=> (acc_done && !stall));
  assert_done_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> !stall);
  assert_fall_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> acc_done);
endmodule

bind xbus_stretch xbus_stretch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .acc_start(acc_start),
  .acc_ext(acc_ext), .mode(mode), .stall(stall), .acc_done(acc_done)
);

// File: tb/xbus_stretch_bench.sv
module xbus_stretch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       acc_start = 1'b0;
  logic       acc_ext = 1'b0;
  logic [2:0] mode = 3'd2;
  logic       ext_wait = 1'b0;
  logic       stall;
  logic       acc_done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  bit live = 0;

  always #2 clk = ~clk;

  xbus_stretch u_xbus_stretch (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_start(acc_start), .acc_ext(acc_ext),
    .mode(mode), .ext_wait(ext_wait), .stall(stall), .acc_done(acc_done)
  );

  function automatic int exp_min(input int fld, input bit wen);
    if (wen && fld == 0) return 2;
    return fld + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: advances on each rising edge.
  bit       m_busy, m_done, m_wl;
  int       m_elapsed, m_need;
  bit [7:0] m_reg;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_wl = 0; m_elapsed = 0; m_need = 0; m_reg = 8'h07;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_elapsed++;
        if (m_elapsed >= m_need && !(m_wl && ext_wait)) begin
          m_busy = 0; m_done = 1;
        end
      end else if (acc_start) begin
        if (acc_ext && (mode == 3'd2 || mode == 3'd3)) begin
          m_busy = 1; m_elapsed = 0;
          m_need = exp_min(int'(m_reg[2:0]), m_reg[7]);
          m_wl = m_reg[7];
        end else m_done = 1;
      end
      if (reg_we) m_reg = reg_wdata & 8'h87;
    end
  end

  always @(negedge clk) begin
    if (live && rst_n) begin
      check(stall == m_busy, "R3 R4 R5 R6 R8 R10 stall", int'(stall), int'(m_busy));
      check(acc_done == m_done, "R9 R6 R7 acc_done", int'(acc_done), int'(m_done));
      check(reg_rdata == m_reg, "R2 reg_rdata", int'(reg_rdata), int'(m_reg));
    end
  end

  task automatic wr(input bit [7:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic run_access(input bit ext, input bit [2:0] md, input int hold,
                            input int wr_at, input bit [7:0] wr_val, input int inj_at,
                            input int exp_stall, input string req);
    int stalls = 0;
    bit got = 0;
    @(negedge clk);
    acc_start = 1; acc_ext = ext; mode = md; ext_wait = (hold > 0);
    reg_we = (wr_at == 0); reg_wdata = wr_val;
    for (int i = 1; i <= 60 && !got; i++) begin
      @(negedge clk);
      acc_start = (i == inj_at); reg_we = (i == wr_at); ext_wait = (i < hold);
      if (acc_done) got = 1;
      else if (stall) stalls++;
    end
    acc_start = 0; reg_we = 0; ext_wait = 0;
    check(got && stalls == exp_stall, req, stalls, exp_stall);
    @(negedge clk);
    check(!acc_done, "R9 single-cycle done", int'(acc_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    check(reg_rdata == 8'h07, "R1 reset register", int'(reg_rdata), 7);
    check(!stall && !acc_done, "R1 reset outputs", int'({stall, acc_done}), 0);

    run_access(1, 3'd2, 0, -1, 8'h00, -1, 8, "R3 default field");
    wr(8'hFF);
    check(reg_rdata == 8'h87, "R2 reserved bits", int'(reg_rdata), 'h87);

    for (int w = 0; w < 2; w++)
      for (int f = 0; f < 8; f++) begin
        wr(8'((w << 7) | f));
        run_access(1, 3'd2, 0, -1, 8'h00, -1, exp_min(f, w[0]),
                   w ? "R4 wait-enabled minimum" : "R3 stretch count");
      end

    wr(8'h81);
    run_access(1, 3'd2, 5, -1, 8'h00, -1, 5, "R5 wait extends");
    run_access(1, 3'd2, 1, -1, 8'h00, -1, 2, "R5 minimum first");
    wr(8'h83);
    run_access(1, 3'd2, 7, -1, 8'h00, -1, 7, "R5 wait after minimum");
    wr(8'h02);
    run_access(1, 3'd2, 6, -1, 8'h00, -1, 3, "R3 wait pin ignored when disabled");

    wr(8'h84);
    run_access(1, 3'd3, 0, -1, 8'h00, -1, 5, "R6 emulation expanded");
    for (int m = 0; m < 8; m++)
      if (m != 2 && m != 3)
        run_access(1, 3'(m), 4, -1, 8'h00, -1, 0, "R6 other mode no stretch");

    run_access(0, 3'd2, 4, -1, 8'h00, -1, 0, "R7 internal access");

    wr(8'h07);
    run_access(1, 3'd2, 0, 3, 8'h00, -1, 8, "R8 write during access");
    run_access(1, 3'd2, 0, -1, 8'h00, -1, 1, "R8 write applies next");
    run_access(1, 3'd2, 0, 0, 8'h05, -1, 1, "R8 same-edge write");
    run_access(1, 3'd2, 0, -1, 8'h00, -1, 6, "R8 same-edge write next");

    wr(8'h03);
    run_access(1, 3'd2, 0, -1, 8'h00, 2, 4, "R10 start during stall");
    @(negedge clk);
    check(!stall, "R10 no extra access", int'(stall), 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule